// File: doc/BRIEF.md
# Multi-Source Reset Release Sequencer

This block is a clocked supervisor core. It merges three fault indications into a pair of active-low reset lines. Two of the indications are level flags from outside comparators: supply valid and secondary sense valid. The third is an active-low manual request pin. When any source is bad, both reset lines drop at once, with no wait for a clock edge. They come back only after every source has stayed good for a set hold-off.

The hold-off is worked out at elaboration time in one of two ways. A clock rate in kHz times a time in milliseconds gives the count, with the time clamped to 100..200 ms. Otherwise a nonzero cycle override is used directly. Any fault that appears while a release is pending clears the count. A manual pulse much shorter than a clock period is caught by the asynchronous clear of the internal state, so it still yields a full hold-off. No separate debounce stage is used, because the hold-off itself absorbs pushbutton bounce.

Each reset line is modelled as an open-drain driver. It has a drive-enable output and a resolved pad level, and the pad level also sees an external pull-low input, so outside logic can hold either line low on its own. Two status outputs are provided: one shows that the hold-off count is running, and one pulses when reset releases.

Top module: `fault_release_sequencer`

## Requirements
- R1: When supply_ok_i is 0, sense_ok_i is 0 or manual_n_i is 0, drv_a_o and drv_b_o are 1 (reset driven), without waiting for a clock edge.
- R2: Let E be the first rising clock edge after all three sources become good, counted as edge 1. Both drive-enables fall at edge HOLD+2: two synchronizer edges, then HOLD counting edges. HOLD is the resolved hold-off count.
- R3: If a fault appears while the hold-off is running, the count is discarded and delay_busy_o drops at once. The full HOLD+2 edges are counted again from when the fault clears.
- R4: A manual_n_i low pulse shorter than one clock period, even one placed between edges, asserts both drive-enables and yields a full HOLD+2 edge hold-off after it ends.
- R5: drv_a_o and drv_b_o are equal at every clock edge.
- R6: rst_a_n_o is 0 exactly when drv_a_o or pull_a_i is 1, and the same holds for rst_b_n_o with drv_b_o and pull_b_i. An external pull on one line changes neither the other pad nor either drive-enable.
- R7: While rst is 1, both drive-enables are 1, both pads are 0, and delay_busy_o and release_pulse_o are 0. After rst falls with all sources good, release follows R2.
- R8: delay_busy_o is 0 after edge 2 of R2, is 1 from edge 3 through edge HOLD+1, and is 0 after the release edge.
- R9: release_pulse_o is 1 for exactly the one cycle after the release edge.
- R10: With no override, HOLD = CLK_KHZ × clamp(DELAY_MS, 100, 200). A nonzero DELAY_OVR sets HOLD directly, with a minimum of 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| supply_ok_i | input | 1 | Supply valid flag, 1 = good |
| sense_ok_i | input | 1 | Secondary sense valid flag, 1 = good |
| manual_n_i | input | 1 | Manual reset request, active low, captured asynchronously |
| pull_a_i | input | 1 | External pull-low on reset line A |
| pull_b_i | input | 1 | External pull-low on reset line B |
| drv_a_o | output | 1 | Drive-enable of line A (1 = driving low) |
| drv_b_o | output | 1 | Drive-enable of line B (1 = driving low) |
| rst_a_n_o | output | 1 | Resolved level of reset line A, active low |
| rst_b_n_o | output | 1 | Resolved level of reset line B, active low |
| delay_busy_o | output | 1 | Hold-off count in progress |
| release_pulse_o | output | 1 | One-cycle pulse when reset releases |

## Verification
The hold-off is exercised with each source failing alone, with two failing together and with all three failing, and every case is expected to release at the same edge. An unequal release time would point to a source being handled by a different path. A fault injected partway through a running count separates a true restart from a count that merely pauses. A sub-cycle manual pulse placed between edges shows whether capture is really asynchronous. Two extra instances, built with out-of-range millisecond settings, show whether the clamp picks the lower or the upper bound.

// File: rtl/rdg_pkg.sv
package rdg_pkg;

    localparam int unsigned N_LANES = 2;
    localparam int unsigned MIN_MS  = 100;
    localparam int unsigned MAX_MS  = 200;
    localparam int unsigned SYNC_ST = 2;

    typedef enum logic [1:0] {
        PH_FAULT = 2'd0,
        PH_COUNT = 2'd1,
        PH_RUN   = 2'd2
    } phase_e;

    typedef struct packed {
        logic supply_ok;
        logic sense_ok;
        logic manual_n;
    } src_t;

    function automatic logic src_fault(src_t s);
        return !(s.supply_ok && s.sense_ok && s.manual_n);
    endfunction

    function automatic int unsigned clamp_ms(int unsigned ms);
        if (ms < MIN_MS) return MIN_MS;
        if (ms > MAX_MS) return MAX_MS;
        return ms;
    endfunction

    function automatic int unsigned hold_cycles(int unsigned khz,
                                                int unsigned ms,
                                                int unsigned ovr);
        if (ovr != 0) return (ovr < 2) ? 2 : ovr;
        return khz * clamp_ms(ms);
    endfunction

endpackage

// File: rtl/rdg_src_qualifier.sv
module rdg_src_qualifier
    import rdg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  src_t src_i,
    output logic flt_async_o,
    output logic qual_ok_o
);

    logic [SYNC_ST-1:0] sync_q;

    assign flt_async_o = src_fault(src_i);

    // Any fault clears the chain without a clock; release is re-timed.
    always_ff @(posedge clk or posedge flt_async_o) begin
        if (flt_async_o) begin
            sync_q <= '0;
        end else if (rst) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_ST-2:0], 1'b1};
        end
    end

    assign qual_ok_o = sync_q[SYNC_ST-1];

endmodule

// File: rtl/rdg_release_timer.sv
module rdg_release_timer
    import rdg_pkg::*;
#(
    parameter int unsigned HOLD = 150000
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   flt_async_i,
    input  logic   qual_ok_i,
    output phase_e phase_o,
    output logic   rel_pulse_o
);

    localparam int unsigned CW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

    phase_e        ph_q;
    logic [CW-1:0] cnt_q;
    logic          pulse_q;

    always_ff @(posedge clk or posedge flt_async_i) begin
        if (flt_async_i) begin
            ph_q    <= PH_FAULT;
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else if (rst) begin
            ph_q    <= PH_FAULT;
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            case (ph_q)
                PH_FAULT: begin
                    if (qual_ok_i) begin
                        ph_q  <= PH_COUNT;
                        cnt_q <= CW'(1);
                    end
                end
                PH_COUNT: begin
                    if (cnt_q == LAST) begin
                        ph_q    <= PH_RUN;
                        cnt_q   <= '0;
                        pulse_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    ph_q <= PH_RUN;
                end
            endcase
        end
    end

    assign phase_o     = ph_q;
    assign rel_pulse_o = pulse_q;

endmodule

// File: rtl/rdg_od_lane.sv
module rdg_od_lane (
    input  logic drive_req_i,
    input  logic ext_pull_i,
    output logic drv_en_o,
    output logic pad_n_o
);

    assign drv_en_o = drive_req_i;
    // Wired level: low if this driver or any outside driver pulls.
    assign pad_n_o  = ~(drive_req_i | ext_pull_i);

endmodule

// File: rtl/fault_release_sequencer.sv
module fault_release_sequencer
    import rdg_pkg::*;
#(
    parameter int unsigned CLK_KHZ   = 1000,
    parameter int unsigned DELAY_MS  = 150,
    parameter int unsigned DELAY_OVR = 0
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok_i,
    input  logic sense_ok_i,
    input  logic manual_n_i,
    input  logic pull_a_i,
    input  logic pull_b_i,
    output logic drv_a_o,
    output logic drv_b_o,
    output logic rst_a_n_o,
    output logic rst_b_n_o,
    output logic delay_busy_o,
    output logic release_pulse_o
);

    localparam int unsigned HOLD = hold_cycles(CLK_KHZ, DELAY_MS, DELAY_OVR);

    src_t               src;
    logic               flt_async;
    logic               qual_ok;
    phase_e             phase;
    logic               drive_req;
    logic [N_LANES-1:0] pull_v;
    logic [N_LANES-1:0] drv_v;
    logic [N_LANES-1:0] pad_v;

    assign src = '{supply_ok: supply_ok_i, sense_ok: sense_ok_i, manual_n: manual_n_i};

    rdg_src_qualifier u_qual (
        .clk         (clk),
        .rst         (rst),
        .src_i       (src),
        .flt_async_o (flt_async),
        .qual_ok_o   (qual_ok)
    );

    rdg_release_timer #(.HOLD(HOLD)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .flt_async_i (flt_async),
        .qual_ok_i   (qual_ok),
        .phase_o     (phase),
        .rel_pulse_o (release_pulse_o)
    );

    assign drive_req    = (phase != PH_RUN) || rst;
    assign delay_busy_o = (phase == PH_COUNT) && !rst;

    assign pull_v = {pull_b_i, pull_a_i};

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        rdg_od_lane u_lane (
            .drive_req_i (drive_req),
            .ext_pull_i  (pull_v[g]),
            .drv_en_o    (drv_v[g]),
            .pad_n_o     (pad_v[g])
        );
    end

    assign drv_a_o   = drv_v[0];
    assign drv_b_o   = drv_v[1];
    assign rst_a_n_o = pad_v[0];
    assign rst_b_n_o = pad_v[1];

endmodule

// File: rtl/rdg_checker.sv
module rdg_checker (
    input logic clk,
    input logic rst,
    input logic supply_ok_i,
    input logic sense_ok_i,
    input logic manual_n_i,
    input logic drv_a_o,
    input logic drv_b_o,
    input logic delay_busy_o,
    input logic release_pulse_o
);

    // R1
    fault_drives_chk: assert property (@(posedge clk) disable iff (rst)
        (!supply_ok_i || !sense_ok_i || !manual_n_i) |-> (drv_a_o && drv_b_o));

    // R5
    lanes_match_chk: assert property (@(posedge clk) disable iff (rst)
        drv_a_o == drv_b_o);

    // R8
    busy_in_reset_chk: assert property (@(posedge clk) disable iff (rst)
        delay_busy_o |-> drv_a_o);

    // R2
    release_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(drv_a_o) |-> $past(delay_busy_o));

    // R9
    pulse_on_release_chk: assert property (@(posedge clk) disable iff (rst)
        release_pulse_o |-> (!drv_a_o && $past(drv_a_o)));

    // R9
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        release_pulse_o |=> !release_pulse_o);

endmodule

bind fault_release_sequencer rdg_checker chk_i (
    .clk             (clk),
    .rst             (rst),
    .supply_ok_i     (supply_ok_i),
    .sense_ok_i      (sense_ok_i),
    .manual_n_i      (manual_n_i),
    .drv_a_o         (drv_a_o),
    .drv_b_o         (drv_b_o),
    .delay_busy_o    (delay_busy_o),
    .release_pulse_o (release_pulse_o)
);

// File: tb/fault_release_sequencer_tb_top.sv
module fault_release_sequencer_tb_top;

    localparam int CLK_PER = 10;
    localparam int HOLD    = 10;
    localparam int EXP_REL = HOLD + 2;
    localparam int EXP_LO  = 100 + 2;
    localparam int EXP_HI  = 200 + 2;
    localparam int NPAT    = 6;
    // {supply_ok, sense_ok, manual_n, hold cycles of the fault}
    localparam logic [6:0] PAT [NPAT] = '{
        {3'b011, 4'd3}, {3'b101, 4'd1}, {3'b110, 4'd4},
        {3'b000, 4'd2}, {3'b010, 4'd5}, {3'b100, 4'd1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic supply_ok = 1'b1, sense_ok = 1'b1, manual_n = 1'b1;
    logic pull_a = 1'b0, pull_b = 1'b0;
    logic drv_a, drv_b, pad_a, pad_b, busy, pulse;
    logic lo_da, lo_db, lo_pa, lo_pb, lo_bz, lo_pl;
    logic hi_da, hi_db, hi_pa, hi_pb, hi_bz, hi_pl;

    int n_chk = 0, n_fail = 0;
    logic busy_k2, busy_k3, busy_rel, pulse_rel;
    bit done = 0;

    always #(CLK_PER/2) clk = ~clk;

    fault_release_sequencer #(.DELAY_OVR(HOLD)) dut_i (
        .clk(clk), .rst(rst), .supply_ok_i(supply_ok), .sense_ok_i(sense_ok),
        .manual_n_i(manual_n), .pull_a_i(pull_a), .pull_b_i(pull_b),
        .drv_a_o(drv_a), .drv_b_o(drv_b), .rst_a_n_o(pad_a), .rst_b_n_o(pad_b),
        .delay_busy_o(busy), .release_pulse_o(pulse));

    fault_release_sequencer #(.CLK_KHZ(1), .DELAY_MS(50)) dut_lo (
        .clk(clk), .rst(rst), .supply_ok_i(supply_ok), .sense_ok_i(sense_ok),
        .manual_n_i(manual_n), .pull_a_i(1'b0), .pull_b_i(1'b0),
        .drv_a_o(lo_da), .drv_b_o(lo_db), .rst_a_n_o(lo_pa), .rst_b_n_o(lo_pb),
        .delay_busy_o(lo_bz), .release_pulse_o(lo_pl));

    fault_release_sequencer #(.CLK_KHZ(1), .DELAY_MS(300)) dut_hi (
        .clk(clk), .rst(rst), .supply_ok_i(supply_ok), .sense_ok_i(sense_ok),
        .manual_n_i(manual_n), .pull_a_i(1'b0), .pull_b_i(1'b0),
        .drv_a_o(hi_da), .drv_b_o(hi_db), .rst_a_n_o(hi_pa), .rst_b_n_o(hi_pb),
        .delay_busy_o(hi_bz), .release_pulse_o(hi_pl));

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Count rising edges until drv_a falls; first edge after the call is 1.
    task automatic wait_release(output int n);
        n = 0;
        busy_k2 = 1'bx; busy_k3 = 1'bx; busy_rel = 1'bx; pulse_rel = 1'bx;
        for (int k = 1; k <= 60; k++) begin
            @(posedge clk); #2;
            if (drv_b !== drv_a) check("R5 lanes differ", drv_b, drv_a);
            if (k == 2) busy_k2 = busy;
            if (k == 3) busy_k3 = busy;
            if (!drv_a) begin
                n = k; busy_rel = busy; pulse_rel = pulse;
                break;
            end
        end
    endtask

    initial begin
        #(CLK_PER * 20000);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int n;
        // R7 reset state
        repeat (3) @(posedge clk);
        #2;
        check("R7 drv_a in reset", drv_a, 1);
        check("R7 drv_b in reset", drv_b, 1);
        check("R7 pads low in reset", {pad_a, pad_b}, 0);
        check("R7 busy/pulse low in reset", {busy, pulse}, 0);
        @(negedge clk); rst = 1'b0;
        wait_release(n);
        check("R7 release after reset", n, EXP_REL);
        check("R8 busy low at edge 2", busy_k2, 0);
        check("R8 busy high at edge 3", busy_k3, 1);
        check("R8 busy low at release", busy_rel, 0);
        check("R9 pulse at release", pulse_rel, 1);
        @(posedge clk); #2;
        check("R9 pulse one cycle", pulse, 0);

        // R1/R2 table walk
        for (int i = 0; i < NPAT; i++) begin
            @(negedge clk);
            {supply_ok, sense_ok, manual_n} = PAT[i][6:4];
            #1;
            check("R1 immediate drive a", drv_a, 1);
            check("R1 immediate drive b", drv_b, 1);
            check("R1 busy cleared", busy, 0);
            repeat (int'(PAT[i][3:0])) @(negedge clk);
            {supply_ok, sense_ok, manual_n} = 3'b111;
            wait_release(n);
            check("R2 release edge", n, EXP_REL);
            check("R9 pulse at release", pulse_rel, 1);
        end

        // R3 fault during pending release restarts count
        @(negedge clk); supply_ok = 1'b0;
        @(negedge clk); supply_ok = 1'b1;
        repeat (6) @(posedge clk);
        @(negedge clk);
        check("R3 busy before fault", busy, 1);
        sense_ok = 1'b0; #1;
        check("R3 busy dropped", busy, 0);
        check("R3 still driving", drv_a, 1);
        @(negedge clk); sense_ok = 1'b1;
        wait_release(n);
        check("R3 full restart", n, EXP_REL);

        // R4 sub-cycle manual pulse between edges
        @(negedge clk); #1;
        manual_n = 1'b0; #1; manual_n = 1'b1; #1;
        check("R4 short pulse captured a", drv_a, 1);
        check("R4 short pulse captured b", drv_b, 1);
        wait_release(n);
        check("R4 full hold after pulse", n, EXP_REL);

        // R6 independent external pulls
        @(negedge clk); pull_a = 1'b1; #1;
        check("R6 pad a pulled", pad_a, 0);
        check("R6 pad b untouched", pad_b, 1);
        check("R6 drive enables untouched", {drv_a, drv_b}, 0);
        @(negedge clk); pull_a = 1'b0; pull_b = 1'b1; #1;
        check("R6 pad b pulled", pad_b, 0);
        check("R6 pad a released", pad_a, 1);
        check("R6 drive enables untouched b", {drv_a, drv_b}, 0);
        @(negedge clk); pull_b = 1'b0;

        // R10 clamped real-time hold-off on the two extra instances
        @(negedge clk); manual_n = 1'b0;
        @(negedge clk); manual_n = 1'b1;
        begin
            int nl = 0, nh = 0;
            for (int k = 1; k <= 260; k++) begin
                @(posedge clk); #2;
                if (nl == 0 && !lo_da) nl = k;
                if (nh == 0 && !hi_da) nh = k;
            end
            check("R10 lower clamp", nl, EXP_LO);
            check("R10 upper clamp", nh, EXP_HI);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule